// File: doc/BRIEF.md
# Multi-channel DMA trigger scheduler

This block decides which of six DMA channels may use a single shared data mover next. Each channel has a peripheral trigger input. A trigger pulse sets a per-channel pending flag. When the mover is idle, the scheduler grants the highest-priority channel that is both pending and enabled. It then presents a burst request on a valid/ready interface. The request carries the channel number, the burst length in words, and a marker for the first burst of a transfer, which the address generator uses to reload its pointers. The mover reports the end of each burst with a one-cycle done pulse, and only after that pulse is a new grant made.

A transfer is a programmable number of bursts, and the scheduler counts the bursts that remain for each channel. In the default mode, one trigger buys exactly one burst. After that burst the channel steps aside for any other waiting channel. A channel with its one-shot bit set runs every burst of its transfer back to back from a single trigger. Each channel can raise one interrupt per transfer, at either the first burst or the last.

The burst request follows valid/ready rules. Once `bst_valid_o` rises, it stays high with channel, length and first-burst marker unchanged until a cycle in which `bst_ready_i` is high. The mover may hold `bst_ready_i` low for any number of cycles. `bst_done_i` is a plain strobe and is only heeded after a request has been accepted.

Top module: `dma_trig_sched`

## Requirements
- R1: After reset, no burst is requested, all interrupt and overflow outputs are low, and every channel's burst counter is empty, so the first burst of any channel starts a new transfer.
- R2: Grants go to the lowest-numbered channel that is pending and enabled. In the default mode (one-shot bit 0), each grant yields exactly one burst. No new grant is made until the done pulse of the current burst.
- R3: The channel that finished the most recent burst is granted only if no other enabled channel is pending, even when it holds a fresh trigger of its own.
- R4: With the one-shot bit set to 1, one trigger makes all bursts of the channel's transfer issue back to back, and no other channel is granted in between.
- R5: A transfer-size value N makes a transfer of N+1 bursts. `bst_first_o` is 1 exactly on the first burst of each transfer.
- R6: `bst_words_o` equals the channel's burst-size value plus one, so a 5-bit value of 0 to 31 gives 1 to 32 words.
- R7: With the interrupt mode bit 0 and the interrupt enable bit 1, the channel's `int_o` bit pulses for one cycle right after the first burst of a transfer is accepted. With the enable bit 0, it stays low.
- R8: With the interrupt mode bit 1, the `int_o` bit pulses for one cycle right after the done pulse of the last burst of a transfer, and at no other burst.
- R9: A trigger that arrives while the same channel's pending flag is still set sets that channel's `ovf_o` bit. The bit stays set until reset, and the extra trigger yields no extra burst.
- R10: A trigger on a disabled channel is held pending but not granted. The channel is served once it is enabled.
- R11: While `bst_valid_o` is high and `bst_ready_i` is low, the request and all its fields hold steady, and a done pulse in that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | NUM_CH | Per-channel peripheral trigger pulses |
| ch_en_i | input | NUM_CH | Per-channel enable |
| oneshot_i | input | NUM_CH | 1: one trigger runs the whole transfer |
| int_end_i | input | NUM_CH | Interrupt point: 0 start of transfer, 1 end |
| int_en_i | input | NUM_CH | Per-channel interrupt enable |
| xfer_size_i | input | NUM_CH*XFER_W | Per channel: bursts per transfer minus one |
| burst_size_i | input | NUM_CH*BW_W | Per channel: words per burst minus one |
| bst_valid_o | output | 1 | Burst request valid |
| bst_ready_i | input | 1 | Mover accepts the request |
| bst_ch_o | output | CH_W | Channel of the request |
| bst_words_o | output | BW_W+1 | Words in the burst |
| bst_first_o | output | 1 | First burst of a transfer (pointer reload) |
| bst_done_i | input | 1 | Mover finished the accepted burst |
| int_o | output | NUM_CH | Per-channel interrupt pulses |
| ovf_o | output | NUM_CH | Sticky per-channel trigger overflow |

## Verification
A trigger registered at one rising edge is granted at the next edge, so `bst_valid_o` is checked two edges after the trigger is driven. A start-of-transfer interrupt appears just after the accepting edge. An end-of-transfer interrupt appears just after the edge that samples the done pulse, and an overflow bit just after the edge that samples the second trigger. The bench drives inputs and samples outputs on the falling edge. Its burst helpers wait for the request, then read `int_o` on the falling edge right after the accept edge and again right after the done edge, so each result is read in the one cycle it is due. Negative checks hold the interface still for several cycles and read the outputs that a wrongly served trigger would have changed.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } sched_st_e;
endpackage

// File: rtl/dma_sched_chan.sv
// Per-channel state: pending trigger, overflow, burst countdown, interrupt.
module dma_sched_chan #(
  parameter int XFER_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              issue_i,
  input  logic              done_i,
  input  logic              oneshot_i,
  input  logic              int_end_i,
  input  logic              int_en_i,
  input  logic [XFER_W-1:0] size_i,
  output logic              pend_o,
  output logic              ovf_o,
  output logic              fresh_o,
  output logic              more_o,
  output logic              int_o
);
  localparam int CNT_W = XFER_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q, ovf_q, int_q;
  logic             fresh, consume;

  assign fresh   = (cnt_q == '0);
  // a continuation burst of a one-shot transfer does not use up a trigger
  assign consume = issue_i && (!oneshot_i || fresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
      cnt_q  <= '0;
      int_q  <= 1'b0;
    end else begin
      if (trig_i)       pend_q <= 1'b1;
      else if (consume) pend_q <= 1'b0;

      if (trig_i && pend_q && !consume) ovf_q <= 1'b1;

      if (issue_i && fresh)
        cnt_q <= CNT_W'(size_i) + CNT_W'(1);
      else if (done_i && !fresh)
        cnt_q <= cnt_q - CNT_W'(1);

      int_q <= int_en_i &&
               ((issue_i && fresh && !int_end_i) ||
                (done_i && (cnt_q == CNT_W'(1)) && int_end_i));
    end
  end

  assign pend_o  = pend_q;
  assign ovf_o   = ovf_q;
  assign fresh_o = fresh;
  assign more_o  = (cnt_q > CNT_W'(1));
  assign int_o   = int_q;
endmodule

// File: rtl/dma_sched_arb.sv
// Fixed-priority pick; the last served channel yields if anyone else waits.
module dma_sched_arb #(
  parameter int NUM_CH = 6,
  parameter int CH_W   = 3
) (
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] last_oh_i,
  output logic              gnt_any_o,
  output logic [CH_W-1:0]   gnt_idx_o
);
  logic [NUM_CH-1:0] others, pool;

  always_comb begin
    others    = req_i & ~last_oh_i;
    pool      = (|others) ? others : req_i;
    gnt_any_o = |pool;
    gnt_idx_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pool[i]) gnt_idx_o = CH_W'(i);
    end
  end
endmodule

// File: rtl/dma_sched_ctrl.sv
// Grant / issue / wait sequencer around the shared data mover.
module dma_sched_ctrl
  import dma_sched_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gnt_any_i,
  input  logic [CH_W-1:0]   gnt_idx_i,
  input  logic              ready_i,
  input  logic              done_i,
  input  logic              cont_i,
  output logic              valid_o,
  output logic [CH_W-1:0]   cur_ch_o,
  output logic              issue_o,
  output logic              done_o,
  output logic [NUM_CH-1:0] last_oh_o
);
  sched_st_e         st_q;
  logic [CH_W-1:0]   cur_q;
  logic [NUM_CH-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      last_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (gnt_any_i) begin
            cur_q <= gnt_idx_i;
            st_q  <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (ready_i) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (done_i) begin
            last_q <= NUM_CH'(1) << cur_q;
            st_q   <= cont_i ? ST_ISSUE : ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign valid_o   = (st_q == ST_ISSUE);
  assign issue_o   = valid_o && ready_i;
  assign done_o    = (st_q == ST_WAIT) && done_i;
  assign cur_ch_o  = cur_q;
  assign last_oh_o = last_q;
endmodule

// File: rtl/dma_trig_sched.sv
module dma_trig_sched #(
  parameter int NUM_CH = 6,
  parameter int XFER_W = 16,
  parameter int BW_W   = 5,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        trig_i,
  input  logic [NUM_CH-1:0]        ch_en_i,
  input  logic [NUM_CH-1:0]        oneshot_i,
  input  logic [NUM_CH-1:0]        int_end_i,
  input  logic [NUM_CH-1:0]        int_en_i,
  input  logic [NUM_CH*XFER_W-1:0] xfer_size_i,
  input  logic [NUM_CH*BW_W-1:0]   burst_size_i,
  output logic                     bst_valid_o,
  input  logic                     bst_ready_i,
  output logic [CH_W-1:0]          bst_ch_o,
  output logic [BW_W:0]            bst_words_o,
  output logic                     bst_first_o,
  input  logic                     bst_done_i,
  output logic [NUM_CH-1:0]        int_o,
  output logic [NUM_CH-1:0]        ovf_o
);
  localparam int WORDS_W = BW_W + 1;

  logic [NUM_CH-1:0] pend, fresh, more, req, last_oh;
  logic              gnt_any, issue, done_hit, cont;
  logic [CH_W-1:0]   gnt_idx, cur_ch;

  assign req  = pend & ch_en_i;
  assign cont = oneshot_i[cur_ch] && more[cur_ch];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    dma_sched_chan #(.XFER_W(XFER_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_i    (trig_i[g]),
      .issue_i   (issue && (cur_ch == CH_W'(g))),
      .done_i    (done_hit && (cur_ch == CH_W'(g))),
      .oneshot_i (oneshot_i[g]),
      .int_end_i (int_end_i[g]),
      .int_en_i  (int_en_i[g]),
      .size_i    (xfer_size_i[g*XFER_W +: XFER_W]),
      .pend_o    (pend[g]),
      .ovf_o     (ovf_o[g]),
      .fresh_o   (fresh[g]),
      .more_o    (more[g]),
      .int_o     (int_o[g])
    );
  end

  dma_sched_arb #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_arb (
    .req_i     (req),
    .last_oh_i (last_oh),
    .gnt_any_o (gnt_any),
    .gnt_idx_o (gnt_idx)
  );

  dma_sched_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt_any_i (gnt_any),
    .gnt_idx_i (gnt_idx),
    .ready_i   (bst_ready_i),
    .done_i    (bst_done_i),
    .cont_i    (cont),
    .valid_o   (bst_valid_o),
    .cur_ch_o  (cur_ch),
    .issue_o   (issue),
    .done_o    (done_hit),
    .last_oh_o (last_oh)
  );

  assign bst_ch_o    = cur_ch;
  assign bst_first_o = fresh[cur_ch];
  assign bst_words_o = WORDS_W'(burst_size_i[cur_ch*BW_W +: BW_W]) + WORDS_W'(1);
endmodule

// File: rtl/dma_sched_chk.sv
module dma_sched_chk #(
  parameter int NUM_CH = 6,
  parameter int BW_W   = 5,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bst_valid_o,
  input logic              bst_ready_i,
  input logic [CH_W-1:0]   bst_ch_o,
  input logic [BW_W:0]     bst_words_o,
  input logic              bst_first_o,
  input logic [NUM_CH-1:0] int_o,
  input logic [NUM_CH-1:0] ovf_o
);
  // R2: an accepted request is never followed by another in the next cycle
  p_one_burst_per_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_valid_o && bst_ready_i) |=> !bst_valid_o);

  // R2: granted channel is a real channel
  p_ch_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid_o |-> ({1'b0, bst_ch_o} < (CH_W+1)'(NUM_CH)));

  // R11: stalled request holds all its fields
  p_hold_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_valid_o && !bst_ready_i) |=> (bst_valid_o && $stable(bst_ch_o)
      && $stable(bst_words_o) && $stable(bst_first_o)));

  // R6: burst length in 1..2**BW_W
  p_words_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid_o |-> (bst_words_o != '0 && !(bst_words_o > (BW_W+1)'(1 << BW_W))));

  // R9: overflow flags are sticky
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_o & $past(ovf_o)) == $past(ovf_o)));

  // R7: interrupts are single-cycle pulses
  p_int_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_o & $past(int_o)) == '0));
endmodule

bind dma_trig_sched dma_sched_chk #(.NUM_CH(NUM_CH), .BW_W(BW_W), .CH_W(CH_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bst_valid_o (bst_valid_o),
  .bst_ready_i (bst_ready_i),
  .bst_ch_o    (bst_ch_o),
  .bst_words_o (bst_words_o),
  .bst_first_o (bst_first_o),
  .int_o       (int_o),
  .ovf_o       (ovf_o)
);

// File: tb/dma_trig_sched_tb_top.sv
module dma_trig_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  trig, en, os, iend, ien;
  logic [95:0] xsz;
  logic [29:0] bsz;
  logic        ready, done;
  logic        bst_valid_o, bst_first_o;
  logic [2:0]  bst_ch_o;
  logic [5:0]  bst_words_o, int_o, ovf_o;
  logic [5:0]  int_issue, int_done;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dma_trig_sched dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .ch_en_i(en), .oneshot_i(os),
    .int_end_i(iend), .int_en_i(ien), .xfer_size_i(xsz), .burst_size_i(bsz),
    .bst_valid_o(bst_valid_o), .bst_ready_i(ready), .bst_ch_o(bst_ch_o),
    .bst_words_o(bst_words_o), .bst_first_o(bst_first_o), .bst_done_i(done),
    .int_o(int_o), .ovf_o(ovf_o)
  );

  // {trigger mask, expected grant order as nibbles, F = none}
  localparam logic [29:0] VEC [6] = '{
    {6'b000001, 24'h0FFFFF},
    {6'b100110, 24'h125FFF},
    {6'b111111, 24'h012345},
    {6'b011000, 24'h34FFFF},
    {6'b010001, 24'h04FFFF},
    {6'b100100, 24'h25FFFF}
  };

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse(input logic [5:0] m);
    trig = m; cyc(); trig = '0;
  endtask

  task automatic take(input int ch, input logic fst, input int words, input string req);
    int w = 0;
    while (!bst_valid_o && w < 50) begin cyc(); w++; end
    chk(req, "valid", bst_valid_o, 1);
    chk(req, "channel", bst_ch_o, ch);
    chk(req, "first", bst_first_o, fst);
    chk(req, "words", bst_words_o, words);
    cyc();
    int_issue = int_o;
  endtask

  task automatic finish_burst();
    done = 1'b1; cyc(); done = 1'b0;
    int_done = int_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    trig = '0; en = '1; os = '0; iend = '0; ien = '0; xsz = '0; bsz = '0;
    ready = 1'b1; done = 1'b0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc();
    chk("R1", "valid after reset", bst_valid_o, 0);
    chk("R1", "int after reset", int_o, 0);
    chk("R1", "ovf after reset", ovf_o, 0);

    // R2 priority order through the vector table (1 burst, 1 word each)
    for (int v = 0; v < 6; v++) begin
      pulse(VEC[v][29:24]);
      for (int k = 0; k < 6; k++) begin
        logic [3:0] nib;
        nib = VEC[v][23-4*k -: 4];
        if (nib != 4'hF) begin
          take(int'(nib), 1'b1, 1, "R2");
          finish_burst();
        end
      end
    end

    // R2/R3: no regrant mid-burst; just-served channel yields
    pulse(6'b000011);
    take(0, 1'b1, 1, "R2");
    pulse(6'b000001);
    chk("R2", "no grant during burst", bst_valid_o, 0);
    finish_burst();
    take(1, 1'b1, 1, "R3");
    finish_burst();
    take(0, 1'b1, 1, "R3");
    finish_burst();

    // R4: one-shot, 3 bursts, ch0 waits
    os[2] = 1'b1; xsz[2*16 +: 16] = 16'd2;
    pulse(6'b000100);
    take(2, 1'b1, 1, "R4");
    pulse(6'b000001);
    finish_burst();
    take(2, 1'b0, 1, "R4");
    finish_burst();
    take(2, 1'b0, 1, "R4");
    finish_burst();
    take(0, 1'b1, 1, "R4");
    finish_burst();
    os[2] = 1'b0;

    // R5/R6: two-burst transfer, 32 words per burst
    xsz[3*16 +: 16] = 16'd1; bsz[3*5 +: 5] = 5'd31;
    pulse(6'b001000); take(3, 1'b1, 32, "R6"); finish_burst();
    pulse(6'b001000); take(3, 1'b0, 32, "R5"); finish_burst();
    pulse(6'b001000); take(3, 1'b1, 32, "R5"); finish_burst();
    pulse(6'b001000); take(3, 1'b0, 32, "R5"); finish_burst();

    // R7: interrupt at start
    ien[1] = 1'b1; iend[1] = 1'b0; xsz[1*16 +: 16] = 16'd1;
    pulse(6'b000010); take(1, 1'b1, 1, "R7");
    chk("R7", "int after first accept", int_issue, 6'b000010);
    finish_burst();
    chk("R7", "int after done", int_done, 0);
    pulse(6'b000010); take(1, 1'b0, 1, "R7");
    chk("R7", "int second burst", int_issue, 0);
    finish_burst();
    chk("R7", "int second done", int_done, 0);

    // R8: interrupt at end
    iend[1] = 1'b1;
    pulse(6'b000010); take(1, 1'b1, 1, "R8");
    chk("R8", "int first accept", int_issue, 0);
    finish_burst();
    chk("R8", "int first done", int_done, 0);
    pulse(6'b000010); take(1, 1'b0, 1, "R8");
    chk("R8", "int last accept", int_issue, 0);
    finish_burst();
    chk("R8", "int last done", int_done, 6'b000010);

    // R7: disabled interrupt
    ien[1] = 1'b0; iend[1] = 1'b0;
    pulse(6'b000010); take(1, 1'b1, 1, "R7");
    chk("R7", "int disabled", int_issue, 0);
    finish_burst();
    pulse(6'b000010); take(1, 1'b0, 1, "R7"); finish_burst();
    chk("R7", "int disabled done", int_done, 0);

    // R10/R9: disabled channel and overflow
    en[4] = 1'b0;
    pulse(6'b010000);
    repeat (3) cyc();
    chk("R10", "disabled not served", bst_valid_o, 0);
    chk("R9", "no ovf on first trig", ovf_o, 0);
    pulse(6'b010000);
    chk("R9", "ovf set", ovf_o, 6'b010000);
    en[4] = 1'b1;
    take(4, 1'b1, 1, "R10");
    finish_burst();
    chk("R9", "ovf sticky", ovf_o, 6'b010000);
    repeat (4) cyc();
    chk("R9", "no extra burst", bst_valid_o, 0);

    // R11: back-pressure
    bsz[5*5 +: 5] = 5'd7; ready = 1'b0;
    pulse(6'b100000);
    cyc();
    chk("R11", "valid", bst_valid_o, 1);
    chk("R11", "channel", bst_ch_o, 5);
    done = 1'b1; cyc(); done = 1'b0;
    chk("R11", "held after stray done", bst_valid_o, 1);
    cyc();
    chk("R11", "words held", bst_words_o, 8);
    chk("R11", "first held", bst_first_o, 1);
    ready = 1'b1;
    cyc();
    chk("R11", "accepted", bst_valid_o, 0);
    finish_burst();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule